// File: doc/BRIEF.md
# Widening Integer Sum Reduction Unit

This unit folds a stream of narrow integer elements into one double-width total. A start request carries the element-width selection, a function code that picks zero- or sign-extension, a vector length and a double-width seed scalar. The unit then takes elements one per cycle over a valid/ready stream. Each element arrives with its own mask bit. Every element whose mask bit is set is first widened to twice the element width and then added to the running total, in arrival (ascending index) order. When the last element has been taken, the unit emits a single write of the double-width total with byte enables. The byte enables cover only the lowest destination element, so the rest of the destination stays as it was.

Element widths of 8, 16 and 32 bits are supported, which gives 16-, 32- and 64-bit totals. A width selection whose doubled size exceeds the accumulator, or a function code other than the two widening sums, is rejected with an illegal pulse. A zero length completes at once with no write. On the element stream, back-pressure is simple: `elem_ready` is high for the whole of a run. An element is consumed on any cycle where `elem_valid` and `elem_ready` are both high. The producer may insert idle cycles by lowering `elem_valid`. While `elem_ready` is low, the stream is not sampled.

Top module: `wred_sum_top`

## Requirements
- R1: An accepted legal start with non-zero length seeds the total with the low 2×SEW bits of `seed`, where SEW is 8 << `sew_sel` for codes 0, 1 and 2.
- R2: Function code 6'b110000 zero-extends each element from SEW bits to 2×SEW bits, and 6'b110001 sign-extends it.
- R3: `elem_ready` is high exactly while a run is in progress. Each cycle with `elem_valid` and `elem_ready` both high consumes one element. Only elements whose `elem_mask` is 1 change the total.
- R4: The total wraps modulo 2^(2×SEW), and `wr_data` bits at and above position 2×SEW read as zero when `wr_en` is high.
- R5: In the cycle after the last element is consumed, `done` and `wr_en` are both high for that one cycle. `wr_be` is then 8'h03, 8'h0F or 8'hFF for `sew_sel` 0, 1 or 2, so that only destination element 0 is written.
- R6: A legal start with `vlen` equal to 0 raises `done` in the following cycle with `wr_en` low, and no element is consumed.
- R7: A start with `sew_sel` equal to 3 (64-bit elements) or with any other function code raises `illegal` for one cycle in the following cycle. It produces no `done`, no write and no run, and leaves `start_idx` unchanged.
- R8: `start_idx` counts the elements consumed in the current run and returns to 0 in the cycle in which `done` is raised.
- R9: `start` is ignored while a run is in progress, and it is accepted again in the cycle in which `done` is high (back-to-back operation).
- R10: After reset, `elem_ready`, `done`, `wr_en` and `illegal` are low and `start_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation; sampled when no run is active |
| funct_code | input | 6 | Operation select: 6'b110000 unsigned, 6'b110001 signed |
| sew_sel | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 (illegal) |
| vlen | input | VL_W | Number of elements in the operation |
| seed | input | 2×MAX_SEW | Initial total, element 0 of the scalar operand |
| elem_valid | input | 1 | Element stream valid |
| elem_ready | output | 1 | Element stream ready, high during a run |
| elem_data | input | MAX_SEW | Element value in the low SEW bits |
| elem_mask | input | 1 | Element participates when 1 |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Rejected-configuration pulse |
| wr_en | output | 1 | Destination write strobe |
| wr_be | output | 2×MAX_SEW/8 | Byte enables of the destination write |
| wr_data | output | 2×MAX_SEW | Double-width total |
| start_idx | output | VL_W | Index of the next element to consume |

## Verification
Two events can fall in the same cycle here: the completion of one run (the `done` and write pulse) and the acceptance of the next start. A second case is the consumption of a final element whose mask bit is clear, together with completion. Both are provoked by holding `start` high through an entire run and by random mask patterns with gaps in `elem_valid`. The bench drives this with a behavioural model that tracks the remaining count, the index and the total with plain integers. That model is compared with every output on every clock, so a lost restart or a misplaced write shows up in the exact cycle it occurs.

// File: rtl/wred_pkg.sv
package wred_pkg;

  localparam logic [5:0] FN_WSUM_U = 6'b110000;
  localparam logic [5:0] FN_WSUM_S = 6'b110001;
  localparam int         SEL_W     = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wred_state_e;

  // number of supported element widths: 8, 16, ... up to max_sew
  function automatic int num_widths(input int max_sew);
    return $clog2(max_sew / 8) + 1;
  endfunction

endpackage

// File: rtl/wred_ctrl.sv
module wred_ctrl
  import wred_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cfg_legal,
  input  logic [VL_W-1:0] vlen,
  input  logic            elem_valid,
  output logic            run,
  output logic            load,
  output logic            accept,
  output logic            done,
  output logic            wr_en,
  output logic            illegal,
  output logic [VL_W-1:0] start_idx
);

  wred_state_e     st_q;
  logic [VL_W-1:0] rem_q;
  logic [VL_W-1:0] idx_q;
  logic            done_q, wr_q, ill_q;
  logic            vl_zero;

  assign vl_zero   = (vlen == '0);
  assign run       = (st_q == ST_RUN);
  assign accept    = run && elem_valid;
  assign load      = !run && start && cfg_legal && !vl_zero;
  assign done      = done_q;
  assign wr_en     = wr_q;
  assign illegal   = ill_q;
  assign start_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      ill_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (!cfg_legal) begin
              ill_q <= 1'b1;
            end else if (vl_zero) begin
              done_q <= 1'b1;
            end else begin
              st_q  <= ST_RUN;
              rem_q <= vlen;
              idx_q <= '0;
            end
          end
        end
        ST_RUN: begin
          if (elem_valid) begin
            if (rem_q == VL_W'(1)) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              wr_q   <= 1'b1;
              idx_q  <= '0;
              rem_q  <= '0;
            end else begin
              rem_q <= rem_q - VL_W'(1);
              idx_q <= idx_q + VL_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !wr_en)); // R7
  AST_IDX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (start_idx == '0)); // R8
  AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done); // R5
  AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (start_idx == '0)); // R8

endmodule

// File: rtl/wred_extend.sv
module wred_extend
  import wred_pkg::*;
#(
  parameter int MAX_SEW = 32,
  localparam int ACC_W  = 2 * MAX_SEW,
  localparam int BE_W   = ACC_W / 8,
  localparam int NW     = num_widths(MAX_SEW)
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic               sgn,
  input  logic [MAX_SEW-1:0] elem,
  output logic [ACC_W-1:0]   ext,
  output logic [ACC_W-1:0]   wmask,
  output logic [BE_W-1:0]    be
);

  logic [ACC_W-1:0] cand_ext [NW];
  logic [ACC_W-1:0] cand_msk [NW];
  logic [BE_W-1:0]  cand_be  [NW];

  for (genvar k = 0; k < NW; k++) begin : g_width
    localparam int W  = 8 << k;
    localparam int DW = 2 * W;
    localparam int DB = DW / 8;
    logic [W-1:0]  narrow;
    logic [DW-1:0] wide;
    assign narrow = elem[W-1:0];
    assign wide   = sgn ? {{W{narrow[W-1]}}, narrow} : {{W{1'b0}}, narrow};
    if (DW == ACC_W) begin : g_full
      assign cand_ext[k] = wide;
      assign cand_msk[k] = '1;
      assign cand_be[k]  = '1;
    end else begin : g_part
      assign cand_ext[k] = {{(ACC_W-DW){1'b0}}, wide};
      assign cand_msk[k] = {{(ACC_W-DW){1'b0}}, {DW{1'b1}}};
      assign cand_be[k]  = {{(BE_W-DB){1'b0}}, {DB{1'b1}}};
    end
  end

  always_comb begin
    ext   = '0;
    wmask = '0;
    be    = '0;
    for (int k = 0; k < NW; k++) begin
      if (sel == SEL_W'(k)) begin
        ext   = cand_ext[k];
        wmask = cand_msk[k];
        be    = cand_be[k];
      end
    end
  end

endmodule

// File: rtl/wred_accum.sv
module wred_accum #(
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] seed,
  input  logic             add_en,
  input  logic [ACC_W-1:0] ext,
  input  logic [ACC_W-1:0] wmask,
  output logic [ACC_W-1:0] sum
);

  logic [ACC_W-1:0] acc_q;

  // full-width add; the modulo-2^(2*SEW) wrap falls out of masking the result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q <= seed;
    end else if (add_en) begin
      acc_q <= acc_q + ext;
    end
  end

  assign sum = acc_q & wmask;

  AST_HOLD_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !add_en) |=> $stable(acc_q)); // R3

endmodule

// File: rtl/wred_sum_top.sv
module wred_sum_top
  import wred_pkg::*;
#(
  parameter int MAX_SEW = 32,
  parameter int VL_W    = 8,
  localparam int ACC_W  = 2 * MAX_SEW,
  localparam int BE_W   = ACC_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [5:0]         funct_code,
  input  logic [SEL_W-1:0]   sew_sel,
  input  logic [VL_W-1:0]    vlen,
  input  logic [ACC_W-1:0]   seed,
  input  logic               elem_valid,
  output logic               elem_ready,
  input  logic [MAX_SEW-1:0] elem_data,
  input  logic               elem_mask,
  output logic               done,
  output logic               illegal,
  output logic               wr_en,
  output logic [BE_W-1:0]    wr_be,
  output logic [ACC_W-1:0]   wr_data,
  output logic [VL_W-1:0]    start_idx
);

  localparam int NW = num_widths(MAX_SEW);

  logic             cfg_legal;
  logic             run, load, accept;
  logic [SEL_W-1:0] sel_q;
  logic             sgn_q;
  logic [ACC_W-1:0] ext, wmask;

  assign cfg_legal = (int'(sew_sel) < NW) &&
                     ((funct_code == FN_WSUM_U) || (funct_code == FN_WSUM_S));

  // operation configuration captured when a run begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      sgn_q <= 1'b0;
    end else if (load) begin
      sel_q <= sew_sel;
      sgn_q <= funct_code[0];
    end
  end

  wred_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_legal (cfg_legal),
    .vlen      (vlen),
    .elem_valid(elem_valid),
    .run       (run),
    .load      (load),
    .accept    (accept),
    .done      (done),
    .wr_en     (wr_en),
    .illegal   (illegal),
    .start_idx (start_idx)
  );

  wred_extend #(.MAX_SEW(MAX_SEW)) u_ext (
    .sel  (sel_q),
    .sgn  (sgn_q),
    .elem (elem_data),
    .ext  (ext),
    .wmask(wmask),
    .be   (wr_be)
  );

  wred_accum #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .seed  (seed),
    .add_en(accept && elem_mask),
    .ext   (ext),
    .wmask (wmask),
    .sum   (wr_data)
  );

  assign elem_ready = run;

  AST_READY_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    elem_ready |-> !illegal); // R7
  AST_BE_ELEMENT0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_be[1:0] == 2'b11)); // R5
  AST_RUN_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(elem_ready) |-> $past(start)); // R9

endmodule

// File: tb/wred_sum_top_tb.sv
module wred_sum_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  funct_code = '0;
  logic [1:0]  sew_sel = '0;
  logic [7:0]  vlen = '0;
  logic [63:0] seed = '0;
  logic        elem_valid = 1'b0;
  logic        elem_ready;
  logic [31:0] elem_data = '0;
  logic        elem_mask = 1'b0;
  logic        done, illegal, wr_en;
  logic [7:0]  wr_be;
  logic [63:0] wr_data;
  logic [7:0]  start_idx;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit chk_on  = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wred_sum_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .funct_code(funct_code),
    .sew_sel(sew_sel), .vlen(vlen), .seed(seed), .elem_valid(elem_valid),
    .elem_ready(elem_ready), .elem_data(elem_data), .elem_mask(elem_mask),
    .done(done), .illegal(illegal), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .start_idx(start_idx)
  );

  // behavioural reference state
  bit          m_run, m_done, m_wr, m_ill, m_sgn;
  int          m_rem, m_idx, m_sew;
  longint unsigned m_acc, m_wdata, m_be;

  function automatic longint unsigned ext_ref(input longint unsigned d, input int s, input bit sg);
    longint unsigned m = (64'd1 << s) - 1;
    longint unsigned e = d & m;
    if (sg && ((e >> (s - 1)) & 1) == 1) e = e | ~m;
    return e;
  endfunction

  function automatic longint unsigned wmask_ref(input int s);
    return (2 * s == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * s)) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_wr = 0; m_ill = 0; m_rem = 0; m_idx = 0;
      m_acc = 0; m_sew = 8; m_sgn = 0; m_wdata = 0; m_be = 0;
    end else begin
      m_done = 0; m_wr = 0; m_ill = 0;
      if (m_run) begin
        if (elem_valid) begin
          if (elem_mask) m_acc = m_acc + ext_ref(64'(elem_data), m_sew, m_sgn);
          m_rem = m_rem - 1;
          if (m_rem == 0) begin
            m_run = 0; m_done = 1; m_wr = 1; m_idx = 0;
            m_wdata = m_acc & wmask_ref(m_sew);
            m_be = (64'd1 << (m_sew / 4)) - 1;
          end else begin
            m_idx = m_idx + 1;
          end
        end
      end else if (start) begin
        if (sew_sel == 2'd3 || (funct_code != 6'b110000 && funct_code != 6'b110001)) m_ill = 1;
        else if (vlen == 0) m_done = 1;
        else begin
          m_run = 1; m_rem = int'(vlen); m_idx = 0;
          m_sew = 8 << sew_sel; m_sgn = funct_code[0]; m_acc = seed;
        end
      end
    end
  end

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !finished) begin
      chk("R3 elem_ready", 64'(elem_ready), 64'(m_run));
      chk("R5 R6 done", 64'(done), 64'(m_done));
      chk("R5 wr_en", 64'(wr_en), 64'(m_wr));
      chk("R7 illegal", 64'(illegal), 64'(m_ill));
      chk("R8 start_idx", 64'(start_idx), 64'(m_idx));
      if (m_wr) begin
        chk("R1 R2 R4 wr_data", wr_data, m_wdata);
        chk("R5 wr_be", 64'(wr_be), m_be);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL R3 watchdog: actual=%0d cycles expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  int tgl = 0;
  task automatic drive_elem(input int mm, input int dm);
    elem_valid = ($urandom % 4) != 0;
    elem_data  = (dm == 1) ? 32'hFFFF_FFFF : $urandom;
    tgl++;
    elem_mask  = (mm == 0) ? 1'b1 : (mm == 1) ? 1'($urandom % 2) : 1'(tgl % 2);
  endtask

  task automatic op(input logic [5:0] f, input logic [1:0] sel, input int n,
                    input logic [63:0] sd, input bit hold, input int mm, input int dm);
    @(negedge clk);
    funct_code = f; sew_sel = sel; vlen = 8'(n); seed = sd; start = 1'b1;
    @(negedge clk);
    start = hold;
    for (int pass = 0; pass < (hold ? 2 : 1); pass++) begin
      for (int g = 0; g < 4000 && m_run; g++) begin
        drive_elem(mm, dm);
        @(negedge clk);
      end
      elem_valid = 1'b0;
      if (hold && pass == 0) begin
        // R9: start still high in the done cycle, so the next run begins now
        @(negedge clk);
        start = 1'b0;
      end
    end
    start = 1'b0; elem_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ready", 64'(elem_ready), 0);
    chk("R10 done", 64'(done), 0);
    chk("R10 wr_en", 64'(wr_en), 0);
    chk("R10 illegal", 64'(illegal), 0);
    chk("R10 start_idx", 64'(start_idx), 0);
    chk_on = 1'b1;

    op(6'b110000, 2'd0, 5, 64'h0000_0000_0000_1234, 0, 0, 0);   // R1 R2 unsigned 8
    op(6'b110001, 2'd0, 7, 64'h0000_0000_0000_0010, 0, 0, 1);   // R2 signed, all -1
    op(6'b110000, 2'd0, 9, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, 1);   // R4 wrap at 16 bits
    op(6'b110001, 2'd1, 12, 64'h1234_5678_9ABC_DEF0, 0, 2, 0);  // R3 alternating mask
    op(6'b110000, 2'd2, 10, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1);  // R4 wrap at 64 bits
    op(6'b110001, 2'd2, 6, 64'h0, 0, 1, 0);                     // R3 random mask
    op(6'b110000, 2'd1, 0, 64'h55, 0, 0, 0);                    // R6 zero length
    op(6'b110000, 2'd3, 4, 64'h55, 0, 0, 0);                    // R7 64-bit elements
    op(6'b000011, 2'd0, 4, 64'h55, 0, 0, 0);                    // R7 other code
    op(6'b110001, 2'd0, 8, 64'h77, 1, 1, 0);                    // R9 start held
    op(6'b110000, 2'd1, 0, 64'h1, 1, 0, 0);                     // R6 R9 zero length held
    for (int i = 0; i < 60; i++) begin
      op((($urandom % 2) == 1) ? 6'b110001 : 6'b110000, 2'($urandom % 3),
         1 + int'($urandom % 40), {$urandom, $urandom}, 1'($urandom % 2), 1, 0);
    end
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule